// File: doc/BRIEF.md
# Reference Edge Prescaler for Phase Comparison

This block sits between an input clock sampler and a digital phase detector. It receives one chosen reference clock, already reduced to single-cycle edge strobes in the fast system clock domain. It emits a one-cycle comparison strobe at the rate the phase detector should work at. Four lock modes share one divider. Pass-through mode forwards every edge. The alternate-rate mode reduces a few high rates to a standard rate. The 8 kHz mode reduces any standard rate to 8 kHz. The programmable mode divides by a shared register value plus one.

The configuration is a mode select, a frequency code, a 16-bit divide value and an edge-polarity select. It is sampled every cycle. Any change to it restarts the divider. A validity flag reports whether the code that is held is legal in the mode that is held. While the configuration is illegal, no comparison strobes come out.

Top module: `refclk_prescaler`

## Requirements
- R1: While reset is high and in the first cycle after it, `cmp_strobe_o` and `cfg_valid_o` are low. The configuration present in the first clock after reset counts as a change.
- R2: Mode 0 (pass-through) accepts frequency codes 0 to 13. Every rising-edge strobe gives one comparison strobe.
- R3: Mode 1 (alternate rates) accepts codes 0 to 3 only. The ratios are 2 (10 MHz), 5 (25 MHz), 2 (62.5 MHz) and 4 (125 MHz). Every other code is illegal.
- R4: Mode 2 (reduce to 8 kHz) uses these ratios: code 2 gives 1, 3 gives 193, 4 gives 256, 5 gives 625, 6 gives 789, 7 gives 810, 8 gives 2430, 9 gives 3240, 11 gives 4860, 12 gives 6480, 13 gives 9720. Code 10 (31.25 MHz has no whole ratio) and codes 14 and 15 are illegal.
- R5: In mode 2, codes 0 (2 kHz) and 1 (4 kHz) fall back to pass-through on rising edges, and the polarity select has no effect.
- R6: In mode 2 with a code of 2 or above, `fall_sel_i` = 1 counts the falling-edge strobes and 0 counts the rising ones. Every other case counts rising-edge strobes only.
- R7: Mode 3 (programmable) divides by `div_n_i` + 1, over the full range 0 to 65535. It accepts codes 0 to 13.
- R8: The comparison strobe comes one cycle after the edge that completes each group of ratio edges. After a restart, the first strobe follows the ratio-th counted edge. The count reloads with no edge lost, so edges on every cycle give a strobe every ratio cycles.
- R9: Any change of mode, code, divide value or polarity restarts the count from zero. The edge in the cycle of the change is not counted.
- R10: `cfg_valid_o` shows whether the configuration sampled at the previous clock is legal. While it is low, no comparison strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_rise_i | input | 1 | One-cycle strobe on each rising edge of the reference |
| edge_fall_i | input | 1 | One-cycle strobe on each falling edge of the reference |
| mode_i | input | 2 | Lock mode: 0 pass-through, 1 alternate, 2 to 8 kHz, 3 programmable |
| freq_code_i | input | 4 | Frequency code, interpreted per mode |
| div_n_i | input | 16 | Shared divide value; ratio is this plus one |
| fall_sel_i | input | 1 | Edge polarity for the 8 kHz reduction |
| cmp_strobe_o | output | 1 | One-cycle phase comparison strobe |
| cfg_valid_o | output | 1 | Held configuration is legal |

## Verification
Each mode is driven with edges on every cycle, to check the exact group length and that no edge is lost at the wrap. Each mode is also driven with sparse random edges, which shows whether idle cycles are wrongly counted. Rising-only and falling-only streams show which edge the polarity control and the low-rate fallback select. Configuration changes in the middle of a group, including a change of polarity alone, tell a real restart apart from a counter that keeps its old phase. Illegal codes in each mode, and the largest divide value, cover the edges of the legal range.

// File: rtl/refclk_prescaler_pkg.sv
package refclk_prescaler_pkg;

    localparam int CODE_W  = 4;
    localparam int DIVN_W  = 16;
    localparam int RATIO_W = DIVN_W + 1;

    localparam logic [CODE_W-1:0] CODE_LOW_2K  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_LOW_4K  = 4'd1;
    localparam logic [CODE_W-1:0] CODE_STD_MAX = 4'd13;
    localparam logic [CODE_W-1:0] CODE_ALT_MAX = 4'd3;
    localparam logic [CODE_W-1:0] CODE_RESET   = 4'd15;

    typedef enum logic [1:0] {
        LM_PASS  = 2'd0,
        LM_ALT   = 2'd1,
        LM_TO8K  = 2'd2,
        LM_PROG  = 2'd3
    } lock_mode_e;

    typedef struct packed {
        lock_mode_e          mode;
        logic [CODE_W-1:0]   code;
        logic [DIVN_W-1:0]   divn;
        logic                fall_sel;
    } cfg_t;

    typedef struct packed {
        logic                legal;
        logic                use_fall;
        logic [RATIO_W-1:0]  ratio;
    } plan_t;

    localparam cfg_t CFG_RESET = '{mode: LM_PASS, code: CODE_RESET,
                                   divn: '0, fall_sel: 1'b0};

    // Ratio that brings a standard rate down to 8 kHz; zero marks no whole ratio.
    function automatic logic [RATIO_W-1:0] to8k_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd0, 4'd1, 4'd2: r = RATIO_W'(1);
            4'd3:  r = RATIO_W'(193);
            4'd4:  r = RATIO_W'(256);
            4'd5:  r = RATIO_W'(625);
            4'd6:  r = RATIO_W'(789);
            4'd7:  r = RATIO_W'(810);
            4'd8:  r = RATIO_W'(2430);
            4'd9:  r = RATIO_W'(3240);
            4'd11: r = RATIO_W'(4860);
            4'd12: r = RATIO_W'(6480);
            4'd13: r = RATIO_W'(9720);
            default: r = '0;
        endcase
        return r;
    endfunction

    // Reduction of an alternate high rate to its standard neighbour.
    function automatic logic [RATIO_W-1:0] alt_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd0:    r = RATIO_W'(2);
            4'd1:    r = RATIO_W'(5);
            4'd2:    r = RATIO_W'(2);
            4'd3:    r = RATIO_W'(4);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refclk_cfg_decode.sv
module refclk_cfg_decode
    import refclk_prescaler_pkg::*;
(
    input  cfg_t  cfg_i,
    output plan_t plan_o
);

    logic [RATIO_W-1:0] r8k;
    logic [RATIO_W-1:0] ralt;
    logic               low_rate;

    assign r8k      = to8k_ratio(cfg_i.code);
    assign ralt     = alt_ratio(cfg_i.code);
    assign low_rate = (cfg_i.code == CODE_LOW_2K) || (cfg_i.code == CODE_LOW_4K);

    always_comb begin
        plan_o.legal    = 1'b0;
        plan_o.use_fall = 1'b0;
        plan_o.ratio    = RATIO_W'(1);
        unique case (cfg_i.mode)
            LM_PASS: begin
                plan_o.legal = (cfg_i.code <= CODE_STD_MAX);
            end
            LM_ALT: begin
                plan_o.legal = (cfg_i.code <= CODE_ALT_MAX);
                if (plan_o.legal) plan_o.ratio = ralt;
            end
            LM_TO8K: begin
                plan_o.legal = (r8k != '0);
                if (plan_o.legal) plan_o.ratio = r8k;
                plan_o.use_fall = plan_o.legal && !low_rate && cfg_i.fall_sel;
            end
            LM_PROG: begin
                plan_o.legal = (cfg_i.code <= CODE_STD_MAX);
                plan_o.ratio = {1'b0, cfg_i.divn} + RATIO_W'(1);
            end
            default: begin
                plan_o.legal = 1'b0;
            end
        endcase
    end

    always_comb begin
        assert_ratio_nonzero_R7 : assert (plan_o.ratio != '0);
    end

endmodule

// File: rtl/refclk_ratio_counter.sv
module refclk_ratio_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             strobe_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == ratio_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= 1'b0;
            if (clear_i) begin
                cnt_q <= '0;
            end else if (enable_i && edge_i) begin
                if (at_last) begin
                    cnt_q    <= '0;
                    strobe_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assert_cnt_below_ratio_R8 : assert property (@(posedge clk) disable iff (rst)
        enable_i |-> (cnt_q < ratio_i));

    assert_strobe_from_edge_R8 : assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> $past(edge_i && enable_i && !clear_i));

endmodule

// File: rtl/refclk_prescaler.sv
module refclk_prescaler
    import refclk_prescaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_rise_i,
    input  logic              edge_fall_i,
    input  logic [1:0]        mode_i,
    input  logic [3:0]        freq_code_i,
    input  logic [15:0]       div_n_i,
    input  logic              fall_sel_i,
    output logic              cmp_strobe_o,
    output logic              cfg_valid_o
);

    cfg_t  cfg_in;
    cfg_t  cfg_q;
    plan_t plan;
    logic  cfg_change;
    logic  edge_pick;

    assign cfg_in = '{mode: lock_mode_e'(mode_i), code: freq_code_i,
                      divn: div_n_i, fall_sel: fall_sel_i};

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_in;
    end

    assign cfg_change = (cfg_in != cfg_q);

    refclk_cfg_decode u_decode (
        .cfg_i  (cfg_q),
        .plan_o (plan)
    );

    assign edge_pick = plan.use_fall ? edge_fall_i : edge_rise_i;

    refclk_ratio_counter #(.CNT_W(RATIO_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (cfg_change),
        .enable_i (plan.legal),
        .edge_i   (edge_pick),
        .ratio_i  (plan.ratio),
        .strobe_o (cmp_strobe_o)
    );

    assign cfg_valid_o = plan.legal;

    assert_unit_ratio_passes_R2 : assert property (@(posedge clk) disable iff (rst)
        (plan.legal && plan.ratio == RATIO_W'(1) && edge_pick && !cfg_change) |=> cmp_strobe_o);

    assert_illegal_is_silent_R10 : assert property (@(posedge clk) disable iff (rst)
        !cfg_valid_o |=> !cmp_strobe_o);

    assert_change_restarts_R9 : assert property (@(posedge clk) disable iff (rst)
        cfg_change |=> !cmp_strobe_o);

endmodule

// File: tb/refclk_prescaler_bench.sv
`timescale 1ns/1ps
module refclk_prescaler_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rise = 1'b0;
    logic        fall = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  code = 4'd0;
    logic [15:0] n = 16'd0;
    logic        pol = 1'b0;
    logic        strobe;
    logic        valid;

    int vectors = 0;
    int errors  = 0;
    int seen    = 0;
    bit done    = 1'b0;

    logic [1:0]  m_mode = 2'd0;
    logic [3:0]  m_code = 4'd15;
    logic [15:0] m_n    = 16'd0;
    logic        m_pol  = 1'b0;
    int          m_cnt  = 0;

    always #2 clk = ~clk;

    refclk_prescaler u_refclk_prescaler (
        .clk          (clk),
        .rst          (rst),
        .edge_rise_i  (rise),
        .edge_fall_i  (fall),
        .mode_i       (mode),
        .freq_code_i  (code),
        .div_n_i      (n),
        .fall_sel_i   (pol),
        .cmp_strobe_o (strobe),
        .cfg_valid_o  (valid)
    );

    function automatic int exp_ratio(input logic [1:0] md, input logic [3:0] cd, input logic [15:0] nv);
        int r;
        r = 0;
        case (md)
            2'd0: r = (cd <= 13) ? 1 : 0;
            2'd1: case (cd) 0: r = 2; 1: r = 5; 2: r = 2; 3: r = 4; default: r = 0; endcase
            2'd2: case (cd)
                      0, 1, 2: r = 1;
                      3: r = 193;  4: r = 256;  5: r = 625;  6: r = 789;
                      7: r = 810;  8: r = 2430; 9: r = 3240; 11: r = 4860;
                      12: r = 6480; 13: r = 9720;
                      default: r = 0;
                  endcase
            default: r = (cd <= 13) ? int'(nv) + 1 : 0;
        endcase
        return r;
    endfunction

    function automatic bit exp_fall(input logic [1:0] md, input logic [3:0] cd, input logic p);
        return (md == 2'd2) && (cd >= 2) && (cd <= 13) && (cd != 10) && p;
    endfunction

    task automatic check(input bit got, input bit exp, input string what, input string tag);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit f, input string tag);
        bit exp_s;
        int rat;
        rise = r;
        fall = f;
        @(posedge clk);
        exp_s = 1'b0;
        rat   = exp_ratio(m_mode, m_code, m_n);
        if ({mode, code, n, pol} != {m_mode, m_code, m_n, m_pol}) begin
            m_cnt = 0;
        end else if (rat != 0 && (exp_fall(m_mode, m_code, m_pol) ? f : r)) begin
            if (m_cnt == rat - 1) begin
                m_cnt = 0;
                exp_s = 1'b1;
            end else begin
                m_cnt++;
            end
        end
        m_mode = mode; m_code = code; m_n = n; m_pol = pol;
        @(negedge clk);
        if (strobe === 1'b1) seen++;
        check(strobe, exp_s, "strobe", tag);
        check(valid, exp_ratio(m_mode, m_code, m_n) != 0, "valid", tag);
    endtask

    task automatic setcfg(input logic [1:0] md, input logic [3:0] cd, input logic [15:0] nv, input logic p);
        mode = md; code = cd; n = nv; pol = p;
    endtask

    task automatic count_check(input int exp, input string tag);
        vectors++;
        if (seen != exp) begin
            errors++;
            $display("FAIL %s strobe count: got %0d expected %0d", tag, seen, exp);
        end
        seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        // R1: outputs quiet during reset
        repeat (3) begin
            rise = 1'b1;
            @(negedge clk);
            check(strobe, 1'b0, "strobe in reset", "R1");
            check(valid, 1'b0, "valid in reset", "R1");
        end
        rst = 1'b0;
        setcfg(2'd0, 4'd3, 16'd0, 1'b0);
        step(1, 0, "R1");
        // R2: pass-through
        for (int i = 0; i < 40; i++) step($urandom % 2, $urandom % 2, "R2");
        setcfg(2'd0, 4'd13, 16'd0, 1'b1);
        for (int i = 0; i < 20; i++) step(1, 0, "R2");
        setcfg(2'd0, 4'd14, 16'd0, 1'b0);
        for (int i = 0; i < 10; i++) step(1, 0, "R10");
        // R3: alternate rates
        for (int c = 0; c < 6; c++) begin
            setcfg(2'd1, 4'(c), 16'd0, 1'b0);
            seen = 0;
            for (int i = 0; i < 60; i++) step(1, 0, "R3");
            count_check((c == 0) ? 29 : (c == 1) ? 11 : (c == 2) ? 29 : (c == 3) ? 14 : 0, "R3");
        end
        // R4: reduce to 8 kHz, edges every cycle
        setcfg(2'd2, 4'd3, 16'd0, 1'b0);
        step(0, 0, "R9");
        seen = 0;
        for (int i = 0; i < 386; i++) step(1, 0, "R4");
        count_check(2, "R4");
        setcfg(2'd2, 4'd10, 16'd0, 1'b0);
        for (int i = 0; i < 20; i++) step(1, 1, "R4");
        setcfg(2'd2, 4'd4, 16'd0, 1'b0);
        for (int i = 0; i < 600; i++) step($urandom % 2, 0, "R4");
        // R5: low rates fall back to rising-edge pass-through
        setcfg(2'd2, 4'd1, 16'd0, 1'b1);
        step(0, 0, "R5");
        seen = 0;
        for (int i = 0; i < 20; i++) step(0, 1, "R5");
        count_check(0, "R5");
        for (int i = 0; i < 20; i++) step(1, 0, "R5");
        count_check(20, "R5");
        // R6: polarity
        setcfg(2'd2, 4'd2, 16'd0, 1'b1);
        step(0, 0, "R6");
        seen = 0;
        for (int i = 0; i < 20; i++) step(0, 1, "R6");
        count_check(20, "R6");
        for (int i = 0; i < 20; i++) step(1, 0, "R6");
        count_check(0, "R6");
        setcfg(2'd0, 4'd2, 16'd0, 1'b1);
        step(0, 0, "R6");
        for (int i = 0; i < 20; i++) step(0, 1, "R6");
        count_check(0, "R6");
        // R7: programmable divide
        setcfg(2'd3, 4'd5, 16'd0, 1'b0);
        for (int i = 0; i < 20; i++) step(1, 0, "R7");
        setcfg(2'd3, 4'd5, 16'd6, 1'b0);
        step(0, 0, "R7");
        seen = 0;
        for (int i = 0; i < 70; i++) step(1, 0, "R7");
        count_check(10, "R7");
        // R9: change mid-group, including polarity alone
        for (int i = 0; i < 4; i++) step(1, 0, "R9");
        pol = 1'b1;
        step(1, 0, "R9");
        seen = 0;
        for (int i = 0; i < 7; i++) step(1, 0, "R9");
        count_check(1, "R9");
        // R7: largest divide value
        setcfg(2'd3, 4'd0, 16'hFFFF, 1'b0);
        step(0, 0, "R7");
        seen = 0;
        for (int i = 0; i < 65536; i++) step(1, 0, "R7");
        count_check(1, "R7");
        // R8: random configurations and sparse edges
        for (int k = 0; k < 80; k++) begin
            setcfg(2'($urandom % 4), 4'($urandom % 16), 16'($urandom % 8), 1'($urandom % 2));
            for (int i = 0; i < 50; i++) step($urandom % 2, $urandom % 2, "R8");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule